// File: doc/BRIEF.md
# AES-128 Key Schedule Step Unit

This unit supplies the two per-round primitives needed to expand an AES-128 key on a 64-bit datapath. The "step" operation takes the upper 32-bit word of operand A, rotates it by one byte (unless the final special round number is given), substitutes each byte through the forward AES S-box, folds in the round constant and returns that word copied into both halves of the 64-bit result. The "merge" operation chains XORs of operand A's upper word with both words of operand B to yield the next two key words.

One key-expansion round on this datapath takes three operations. First, a step on the pair {w3,w2} with the round number. Second, a merge of that result with {w1,w0}, which gives {w5,w4}. Third, a merge of {w5,w4} with {w3,w2}, which gives {w7,w6}. Each 32-bit word holds the key bytes in little-endian order: the first key byte sits in bits 7:0.

Each request is presented for one cycle with `in_valid`. The result and its flag are registered and appear one cycle later, marked by `out_valid`.

Top module: `aes_keystep_unit`

## Requirements
- R1: After reset, `out_valid`, `result` and `illegal` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `result` and `illegal` keep their values.
- R3: With `op_sel`=0 (step) and `round_num` below 10, the input word is `opa[63:32]` rotated right by 8 bits. Each of its four bytes is replaced by its forward AES S-box value. The round constant is XORed into bits 7:0. The resulting 32-bit word appears in both `result[63:32]` and `result[31:0]`.
- R4: The round constant for round numbers 0 to 9 is, in order: 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0x1B, 0x36.
- R5: For a step with `round_num`=10, there is no rotation and the round constant is zero. The result is the S-box substitution of `opa[63:32]`, replicated into both halves.
- R6: For a step with `round_num` from 11 to 15, `illegal` is 1 and `result` is zero. For any legal request, `illegal` is 0.
- R7: With `op_sel`=1 (merge), `result[31:0]` = `opa[63:32]` ^ `opb[31:0]` and `result[63:32]` = `opa[63:32]` ^ `opb[31:0]` ^ `opb[63:32]`.
- R8: A merge ignores `round_num`: a merge with a round number from 11 to 15 gives `illegal`=0 and the R7 value.
- R9: A step ignores `opb` and `opa[31:0]`.
- R10: Iterating the step and merge operations from the standard AES-128 example key 2b7e151628aed2a6abf7158809cf4f3c reproduces all eleven round keys. The last of these is d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 1 | 0 = step, 1 = merge |
| round_num | input | 4 | Round number for the step operation |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B, used by merge only |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Registered result |
| illegal | output | 1 | Step requested with round number above 10 |

## Verification
The round-number decode and the merge datapath are both active on every request. The case of interest is a merge that carries an out-of-range round number in the same cycle. The bench issues merges with round numbers 11 to 15 and expects `illegal` to stay low and the R7 value to appear. It then issues steps with the same round numbers and expects the flag to rise and the result to be zero. The hold behaviour is judged by changing every operand while `in_valid` is low and checking that the registered outputs do not move.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

   typedef enum logic {
      KS_OP_STEP  = 1'b0,
      KS_OP_MERGE = 1'b1
   } ks_op_e;

   function automatic logic [7:0] ks_xtime(input logic [7:0] v);
      return {v[6:0], 1'b0} ^ (v[7] ? 8'h1B : 8'h00);
   endfunction

   function automatic logic [7:0] ks_gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = ks_xtime(sh);
      end
      return acc;
   endfunction

   // multiplicative inverse as x^254 (0 maps to 0)
   function automatic logic [7:0] ks_ginv(input logic [7:0] x);
      logic [7:0] r;
      logic [7:0] e;
      r = 8'h01;
      e = 8'd254;
      for (int i = 7; i >= 0; i--) begin
         r = ks_gmul(r, r);
         if (e[i]) r = ks_gmul(r, x);
      end
      return r;
   endfunction

   function automatic logic [7:0] ks_affine(input logic [7:0] b);
      logic [7:0] o;
      logic [7:0] c;
      c = 8'h63;
      for (int i = 0; i < 8; i++) begin
         o[i] = b[i] ^ b[(i + 4) % 8] ^ b[(i + 5) % 8] ^ b[(i + 6) % 8] ^ b[(i + 7) % 8] ^ c[i];
      end
      return o;
   endfunction

   function automatic logic [7:0] ks_rcon(input logic [7:0] r);
      logic [7:0] v;
      v = 8'h01;
      for (int i = 0; i < 16; i++) begin
         if (i < int'(r)) v = ks_xtime(v);
      end
      return v;
   endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox
   import aes_ks_pkg::*;
(
   input  logic [7:0] byte_in,
   output logic [7:0] byte_out
);

   always_comb begin
      byte_out = ks_affine(ks_ginv(byte_in));
   end

endmodule

// File: rtl/aes_ks_step.sv
module aes_ks_step
   import aes_ks_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int RND_W    = 4,
   parameter int LAST_RND = 10
) (
   input  logic [WORD_W-1:0] src_word,
   input  logic [RND_W-1:0]  round_num,
   output logic [WORD_W-1:0] word_out,
   output logic              bad_round
);

   localparam int LANES = WORD_W / 8;
   localparam logic [RND_W-1:0] LAST_R = RND_W'(LAST_RND);

   logic              is_last;
   logic [WORD_W-1:0] rot_word;
   logic [WORD_W-1:0] sub_word;
   logic [7:0]        rcon;

   assign is_last   = (round_num == LAST_R);
   assign bad_round = (round_num > LAST_R);
   assign rot_word  = is_last ? src_word : {src_word[7:0], src_word[WORD_W-1:8]};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      aes_ks_sbox u_sbox (
         .byte_in  (rot_word[8*g +: 8]),
         .byte_out (sub_word[8*g +: 8])
      );
   end

   always_comb begin
      rcon = 8'h00;
      if (round_num < LAST_R) rcon = ks_rcon(8'(round_num));
   end

   assign word_out = sub_word ^ {{(WORD_W-8){1'b0}}, rcon};

endmodule

// File: rtl/aes_ks_merge.sv
module aes_ks_merge #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0]   upper_a,
   input  logic [2*WORD_W-1:0] opb,
   output logic [2*WORD_W-1:0] merged
);

   logic [WORD_W-1:0] lo_word;

   assign lo_word = upper_a ^ opb[WORD_W-1:0];
   assign merged  = {lo_word ^ opb[2*WORD_W-1:WORD_W], lo_word};

endmodule

// File: rtl/aes_keystep_unit.sv
module aes_keystep_unit
   import aes_ks_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int RND_W    = 4,
   parameter int LAST_RND = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              op_sel,
   input  logic [RND_W-1:0]  round_num,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              illegal
);

   localparam int WORD_W = DATA_W / 2;

   if (WORD_W != 32) begin : g_bad_width
      $error("aes_keystep_unit: DATA_W must be 64");
   end
   if ((1 << RND_W) <= LAST_RND) begin : g_bad_rnd
      $error("aes_keystep_unit: RND_W too narrow for LAST_RND");
   end

   logic [WORD_W-1:0] step_word;
   logic              step_bad;
   logic [DATA_W-1:0] merge_val;
   logic [DATA_W-1:0] next_res;
   logic              next_bad;
   ks_op_e            op;

   assign op = ks_op_e'(op_sel);

   aes_ks_step #(
      .WORD_W   (WORD_W),
      .RND_W    (RND_W),
      .LAST_RND (LAST_RND)
   ) u_step (
      .src_word  (opa[DATA_W-1:WORD_W]),
      .round_num (round_num),
      .word_out  (step_word),
      .bad_round (step_bad)
   );

   aes_ks_merge #(
      .WORD_W (WORD_W)
   ) u_merge (
      .upper_a (opa[DATA_W-1:WORD_W]),
      .opb     (opb),
      .merged  (merge_val)
   );

   always_comb begin
      next_bad = 1'b0;
      if (op == KS_OP_MERGE) begin
         next_res = merge_val;
      end else if (step_bad) begin
         next_res = '0;
         next_bad = 1'b1;
      end else begin
         next_res = {step_word, step_word};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= next_res;
            illegal <= next_bad;
         end
      end
   end

endmodule

// File: rtl/aes_keystep_unit_chk.sv
module aes_keystep_unit_chk #(
   parameter int DATA_W   = 64,
   parameter int RND_W    = 4,
   parameter int LAST_RND = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              op_sel,
   input logic [RND_W-1:0]  round_num,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              illegal
);

   localparam int W = DATA_W / 2;
   localparam logic [RND_W-1:0] LAST_R = RND_W'(LAST_RND);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(illegal))); // R2
   AST_STEP_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_sel) |=> (result[DATA_W-1:W] == result[W-1:0])); // R3
   AST_ILLEGAL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_sel && round_num > LAST_R) |=> (illegal && result == '0)); // R6
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (result == '0)); // R6
   AST_MERGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel) |=> !illegal); // R8
   AST_MERGE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel) |=>
         (result[W-1:0] == ($past(opa[DATA_W-1:W]) ^ $past(opb[W-1:0])))); // R7

endmodule

bind aes_keystep_unit aes_keystep_unit_chk #(
   .DATA_W   (DATA_W),
   .RND_W    (RND_W),
   .LAST_RND (LAST_RND)
) u_chk (.*);

// File: tb/aes_keystep_unit_bench.sv
module aes_keystep_unit_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_sel = 1'b0;
   logic [3:0]  round_num = 4'd0;
   logic [63:0] opa = 64'd0;
   logic [63:0] opb = 64'd0;
   logic        out_valid;
   logic [63:0] result;
   logic        illegal;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aes_keystep_unit u_aes_keystep_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_sel    (op_sel),
      .round_num (round_num),
      .opa       (opa),
      .opb       (opb),
      .out_valid (out_valid),
      .result    (result),
      .illegal   (illegal)
   );

   // ---------------- reference model ----------------
   function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = 16'd0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] ref_sbox(input logic [7:0] x);
      logic [7:0] inv;
      logic [7:0] r;
      inv = 8'h00;
      for (int c = 1; c < 256; c++) if (ref_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
      r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
              ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      return r;
   endfunction

   function automatic logic [7:0] ref_rcon(input int r);
      case (r)
         0: return 8'h01;  1: return 8'h02;  2: return 8'h04;  3: return 8'h08;
         4: return 8'h10;  5: return 8'h20;  6: return 8'h40;  7: return 8'h80;
         8: return 8'h1B;  9: return 8'h36;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [63:0] ref_step(input logic [63:0] a, input int r);
      logic [31:0] w;
      logic [31:0] s;
      w = a[63:32];
      if (r != 10) w = {w[7:0], w[31:8]};
      for (int i = 0; i < 4; i++) s[8*i +: 8] = ref_sbox(w[8*i +: 8]);
      s[7:0] = s[7:0] ^ ref_rcon(r);
      return {s, s};
   endfunction

   function automatic logic [63:0] ref_merge(input logic [63:0] a, input logic [63:0] b);
      logic [31:0] lo;
      lo = a[63:32] ^ b[31:0];
      return {lo ^ b[63:32], lo};
   endfunction

   // ---------------- helpers ----------------
   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp_v);
      end
   endtask

   // issue one request; returns sampled outputs one cycle later
   task automatic issue(input logic op, input logic [3:0] rn, input logic [63:0] a,
                        input logic [63:0] b, output logic [63:0] res,
                        output logic bad, output logic vld);
      @(negedge clk);
      in_valid  = 1'b1;
      op_sel    = op;
      round_num = rn;
      opa       = a;
      opb       = b;
      @(negedge clk);
      in_valid = 1'b0;
      res = result;
      bad = illegal;
      vld = out_valid;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check("R1 out_valid", 64'(out_valid), 64'd0);
      check("R1 result", result, 64'd0);
      check("R1 illegal", 64'(illegal), 64'd0);
   endtask

   task automatic t_step_rounds();
      logic [63:0] res;
      logic bad;
      logic vld;
      logic [63:0] a;
      for (int r = 0; r < 10; r++) begin
         a = 64'h0123_4567_89AB_CDEF ^ (64'(r) * 64'h1357_9BDF_0246_8ACE);
         issue(1'b0, 4'(r), a, 64'hFFFF_0000_AAAA_5555, res, bad, vld);
         check("R3 step value", res, ref_step(a, r));
         check("R2 out_valid after request", 64'(vld), 64'd1);
         check("R6 legal step no flag", 64'(bad), 64'd0);
      end
      // R4: zero word makes rcon visible: S(00)=63 in every byte, low byte ^ rcon
      for (int r = 0; r < 10; r++) begin
         issue(1'b0, 4'(r), 64'd0, 64'd0, res, bad, vld);
         check("R4 round constant", 64'(res[7:0] ^ 8'h63), 64'(ref_rcon(r)));
      end
      // R5: no rotation and no constant
      issue(1'b0, 4'd10, 64'h0001_5300_0000_0000, 64'd0, res, bad, vld);
      check("R5 round ten", res, 64'h63_7C_ED_63_63_7C_ED_63);
      check("R5 round ten flag", 64'(bad), 64'd0);
      // R3 known value: word 0x00000053 rotated -> 0x53000000 -> ED636363, ^01
      issue(1'b0, 4'd0, 64'h0000_0053_0000_0000, 64'd0, res, bad, vld);
      check("R3 known step", res, 64'hED63_6362_ED63_6362);
   endtask

   task automatic t_ignore_inputs();
      logic [63:0] r1;
      logic [63:0] r2;
      logic bad;
      logic vld;
      issue(1'b0, 4'd3, 64'hDEAD_BEEF_0000_0000, 64'd0, r1, bad, vld);
      issue(1'b0, 4'd3, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, r2, bad, vld);
      check("R9 step ignores opb and low opa", r2, r1);
   endtask

   task automatic t_illegal_and_merge();
      logic [63:0] res;
      logic bad;
      logic vld;
      logic [63:0] a;
      logic [63:0] b;
      for (int r = 11; r < 16; r++) begin
         issue(1'b0, 4'(r), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, res, bad, vld);
         check("R6 illegal flag", 64'(bad), 64'd1);
         check("R6 illegal zero result", res, 64'd0);
         a = 64'hA5A5_0F0F_1111_2222 + 64'(r);
         b = 64'h3C3C_C3C3_7777_8888 ^ (64'(r) << 40);
         issue(1'b1, 4'(r), a, b, res, bad, vld);
         check("R8 merge with bad round no flag", 64'(bad), 64'd0);
         check("R8 merge value with bad round", res, ref_merge(a, b));
      end
      issue(1'b1, 4'd2, 64'h0000_0001_FFFF_FFFF, 64'h0000_0010_0000_0100, res, bad, vld);
      check("R7 merge value", res, 64'h0000_0111_0000_0101);
   endtask

   task automatic t_hold();
      logic [63:0] res;
      logic bad;
      logic vld;
      issue(1'b0, 4'd12, 64'd5, 64'd6, res, bad, vld);
      @(negedge clk);
      in_valid  = 1'b0;
      op_sel    = 1'b1;
      round_num = 4'd1;
      opa       = 64'hFFFF_FFFF_0000_0000;
      opb       = 64'h1234_1234_1234_1234;
      @(negedge clk);
      check("R2 no valid when idle", 64'(out_valid), 64'd0);
      check("R2 result held", result, 64'd0);
      check("R2 illegal held", 64'(illegal), 64'd1);
   endtask

   task automatic t_key_expansion();
      logic [63:0] lo_pair;
      logic [63:0] hi_pair;
      logic [63:0] t;
      logic [63:0] n_lo;
      logic [63:0] n_hi;
      logic [63:0] e_lo;
      logic [63:0] e_hi;
      logic bad;
      logic vld;
      // little-endian words of 2b7e1516 28aed2a6 abf71588 09cf4f3c
      lo_pair = {32'hA6D2AE28, 32'h16157E2B};
      hi_pair = {32'h3C4FCF09, 32'h8815F7AB};
      for (int r = 0; r < 10; r++) begin
         t = ref_step(hi_pair, r);
         e_lo = ref_merge(t, lo_pair);
         e_hi = ref_merge(e_lo, hi_pair);
         issue(1'b0, 4'(r), hi_pair, 64'd0, t, bad, vld);
         issue(1'b1, 4'd0, t, lo_pair, n_lo, bad, vld);
         issue(1'b1, 4'd0, n_lo, hi_pair, n_hi, bad, vld);
         check("R10 round key low", n_lo, e_lo);
         check("R10 round key high", n_hi, e_hi);
         if (r == 0) begin
            check("R10 first round key low", n_lo, {32'hB12C5488, 32'h17FEFAA0});
            check("R10 first round key high", n_hi, {32'h05766C2A, 32'h3939A323});
         end
         lo_pair = n_lo;
         hi_pair = n_hi;
      end
      check("R10 last round key low", lo_pair, {32'h8925EEC9, 32'hA8F914D0});
      check("R10 last round key high", hi_pair, {32'hA60C63B6, 32'hC80C3FE1});
   endtask

   // ---------------- main ----------------
   logic done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_step_rounds();
      t_ignore_inputs();
      t_illegal_and_merge();
      t_hold();
      t_key_expansion();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule